// File: doc/BRIEF.md
# External Bus Arbiter with Wait States

This block shares one external address bus and one external data bus between two on-chip requesters: a program-memory port and a data-memory port. The program port can mark its access as a boot-space fetch. Each winning access is placed on the external pins and held there for a number of cycles set by a 3-bit wait-state value for its space, so that slow memories and memory-mapped peripherals can be reached. A one-hot space-select output shows which space owns the current external cycle.

An outside master can take the whole bus. It raises a request line, and the block answers with a grant once no access is running. While the bus is lent out, the block stops driving the address, data and select lines, which is shown by its output enable going low. A mode input sets what the core does during a grant. In continue mode the core stalls only if one of its ports wants the external bus. In halt mode the core is stalled for the whole grant.

Top module: `ext_bus_arbiter`

## Requirements
- R1: During and directly after reset, ext_grant, space_sel, pm_done, dm_done and core_stall are all 0, and ext_oe is 1.
- R2: An access keeps space_sel non-zero for exactly W+1 cycles, where W is the wait-state value of its space (W=0 gives one cycle). space_sel is one-hot during the access, and the owning port's done output is 1 in the last of those cycles only.
- R3: W is taken at the start of the access from ws_dm for data accesses, from ws_boot for program accesses with pm_boot=1, and from ws_pm for other program accesses.
- R4: During an access, ext_addr, ext_wdata and ext_we carry the owning port's values and stay stable. rd_data equals ext_rdata in the cycle when done is 1.
- R5: space_sel bit 0 marks program space, bit 1 marks data space and bit 2 marks boot space. If both ports request in the same cycle, the data port is served first and the program port starts after the data access ends.
- R6: After every access, space_sel is 0 for one cycle before anything else owns the bus.
- R7: ext_grant rises only when no access is in progress. An ext_req raised during an access is granted only after that access has ended.
- R8: While ext_grant is 1, ext_oe is 0 and space_sel is 0. ext_grant falls one cycle after ext_req falls.
- R9: With halt_mode=0, core_stall is 1 during a grant only while pm_req or dm_req is 1. core_stall is never 1 outside a grant.
- R10: With halt_mode=1, core_stall is 1 for the whole grant, even with no port request.
- R11: A port request made during a grant gets no done until the grant ends, and is then served.
- R12: When ext_req and a port request are both present while the bus is idle, the external master wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_mode | input | 1 | 1: core stalls for the whole grant; 0: core keeps running |
| ws_pm | input | WSW | Wait states for program-space accesses |
| ws_dm | input | WSW | Wait states for data-space accesses |
| ws_boot | input | WSW | Wait states for boot-space accesses |
| pm_req | input | 1 | Program port access request, held until pm_done |
| pm_boot | input | 1 | Program request targets boot space |
| pm_addr | input | AW | Program port address |
| pm_we | input | 1 | Program port write enable |
| pm_wdata | input | DW | Program port write data |
| pm_done | output | 1 | Program access completes this cycle |
| dm_req | input | 1 | Data port access request, held until dm_done |
| dm_addr | input | AW | Data port address |
| dm_we | input | 1 | Data port write enable |
| dm_wdata | input | DW | Data port write data |
| dm_done | output | 1 | Data access completes this cycle |
| rd_data | output | DW | Read data returned to the ports |
| ext_req | input | 1 | Outside master asks for the bus |
| ext_grant | output | 1 | Bus is lent to the outside master |
| core_stall | output | 1 | Core must stall because of the grant |
| ext_addr | output | AW | External address bus |
| ext_wdata | output | DW | External write data |
| ext_we | output | 1 | External write strobe |
| ext_rdata | input | DW | External read data |
| ext_oe | output | 1 | Block drives the external address, data and select lines |
| space_sel | output | 3 | One-hot owner of the external cycle (program, data, boot) |

## Verification
Single accesses are tried with random spaces, addresses and wait values from 0 to 7. This separates the three wait-state fields from each other and shows whether the length counts W+1 or is off by one. A directed run with both ports requesting in the same cycle shows the priority order and the idle gap. An outside request raised in the middle of a long access shows whether a grant can land inside a wait-stated cycle. Grants are tried in both modes, with and without a pending port request, to tell the stall in continue mode apart from the stall in halt mode.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_XFER = 2'd1,
      BUS_LENT = 2'd2
   } bus_state_t;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_PM   = 2'd1,
      OWN_DM   = 2'd2
   } owner_t;

   localparam int SPACES   = 3;
   localparam int SEL_PM   = 0;
   localparam int SEL_DM   = 1;
   localparam int SEL_BOOT = 2;
endpackage

// File: rtl/ext_bus_wait_ctr.sv
module ext_bus_wait_ctr #(
   parameter int WSW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [WSW-1:0] load_val,
   input  logic           active,
   output logic           last
);
   generate
      if (WSW < 1) begin : g_bad_wsw
         $error("ext_bus_wait_ctr: WSW must be at least 1");
      end
   endgenerate

   logic [WSW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (active && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign last = active && (cnt == '0);

   // R2: each busy cycle before the last one takes one count away
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ext_bus_pick.sv
module ext_bus_pick #(
   parameter bit DM_FIRST = 1'b1
) (
   input  logic pm_req,
   input  logic dm_req,
   input  logic ext_req,
   output logic take_ext,
   output logic take_dm,
   output logic take_pm
);
   generate
      if (DM_FIRST) begin : g_dm_first
         always_comb begin
            take_ext = ext_req;
            take_dm  = !ext_req && dm_req;
            take_pm  = !ext_req && !dm_req && pm_req;
         end
      end else begin : g_pm_first
         always_comb begin
            take_ext = ext_req;
            take_pm  = !ext_req && pm_req;
            take_dm  = !ext_req && !pm_req && dm_req;
         end
      end
   endgenerate
endmodule

// File: rtl/ext_bus_drive.sv
module ext_bus_drive #(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int NS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [NS-1:0] load_space,
   input  logic [AW-1:0] load_addr,
   input  logic [DW-1:0] load_wdata,
   input  logic          load_we,
   input  logic          finish,
   input  logic          lent,
   output logic [AW-1:0] ext_addr,
   output logic [DW-1:0] ext_wdata,
   output logic          ext_we,
   output logic [NS-1:0] space_sel,
   output logic          ext_oe
);
   generate
      if (AW < 1 || DW < 1 || NS < 1) begin : g_bad_width
         $error("ext_bus_drive: widths must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_addr  <= '0;
         ext_wdata <= '0;
         ext_we    <= 1'b0;
         space_sel <= '0;
      end else if (load) begin
         ext_addr  <= load_addr;
         ext_wdata <= load_wdata;
         ext_we    <= load_we;
         space_sel <= load_space;
      end else if (finish) begin
         ext_we    <= 1'b0;
         space_sel <= '0;
      end
   end

   assign ext_oe = !lent;

   // R8: nothing is marked as owning the bus while the pins are released
   p_quiet_when_lent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_oe) |-> (space_sel == '0));
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter int WSW      = 3,
   parameter bit DM_FIRST = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           halt_mode,
   input  logic [WSW-1:0] ws_pm,
   input  logic [WSW-1:0] ws_dm,
   input  logic [WSW-1:0] ws_boot,
   input  logic           pm_req,
   input  logic           pm_boot,
   input  logic [AW-1:0]  pm_addr,
   input  logic           pm_we,
   input  logic [DW-1:0]  pm_wdata,
   output logic           pm_done,
   input  logic           dm_req,
   input  logic [AW-1:0]  dm_addr,
   input  logic           dm_we,
   input  logic [DW-1:0]  dm_wdata,
   output logic           dm_done,
   output logic [DW-1:0]  rd_data,
   input  logic           ext_req,
   output logic           ext_grant,
   output logic           core_stall,
   output logic [AW-1:0]  ext_addr,
   output logic [DW-1:0]  ext_wdata,
   output logic           ext_we,
   input  logic [DW-1:0]  ext_rdata,
   output logic           ext_oe,
   output logic [2:0]     space_sel
);
   import ext_bus_pkg::*;

   localparam int NS = SPACES;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_bus
         $error("ext_bus_arbiter: AW and DW must be at least 1");
      end
      if (WSW < 1 || WSW > 8) begin : g_bad_ws
         $error("ext_bus_arbiter: WSW must be in 1..8");
      end
      if (NS != 3) begin : g_bad_ns
         $error("ext_bus_arbiter: space count must be 3");
      end
   endgenerate

   bus_state_t     state, state_nx;
   owner_t         owner;
   logic           take_ext, take_dm, take_pm;
   logic           load, last, lent;
   logic [WSW-1:0] load_ws;
   logic [NS-1:0]  load_space;
   logic [AW-1:0]  load_addr;
   logic [DW-1:0]  load_wdata;
   logic           load_we;

   ext_bus_pick #(.DM_FIRST(DM_FIRST)) u_pick (
      .pm_req   (pm_req),
      .dm_req   (dm_req),
      .ext_req  (ext_req),
      .take_ext (take_ext),
      .take_dm  (take_dm),
      .take_pm  (take_pm)
   );

   assign load = (state == BUS_IDLE) && (take_dm || take_pm);
   assign lent = (state == BUS_LENT);

   always_comb begin
      load_space = '0;
      if (take_dm) begin
         load_ws              = ws_dm;
         load_addr            = dm_addr;
         load_wdata           = dm_wdata;
         load_we              = dm_we;
         load_space[SEL_DM]   = 1'b1;
      end else begin
         load_ws              = pm_boot ? ws_boot : ws_pm;
         load_addr            = pm_addr;
         load_wdata           = pm_wdata;
         load_we              = pm_we;
         load_space[SEL_PM]   = !pm_boot;
         load_space[SEL_BOOT] = pm_boot;
      end
   end

   ext_bus_wait_ctr #(.WSW(WSW)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_ws),
      .active   (state == BUS_XFER),
      .last     (last)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         BUS_IDLE: begin
            if (take_ext)
               state_nx = BUS_LENT;
            else if (take_dm || take_pm)
               state_nx = BUS_XFER;
         end
         BUS_XFER: if (last) state_nx = BUS_IDLE;
         BUS_LENT: if (!ext_req) state_nx = BUS_IDLE;
         default:  state_nx = BUS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= BUS_IDLE;
         owner <= OWN_NONE;
      end else begin
         state <= state_nx;
         if (load)
            owner <= take_dm ? OWN_DM : OWN_PM;
         else if (last)
            owner <= OWN_NONE;
      end
   end

   ext_bus_drive #(.AW(AW), .DW(DW), .NS(NS)) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_space (load_space),
      .load_addr  (load_addr),
      .load_wdata (load_wdata),
      .load_we    (load_we),
      .finish     (last),
      .lent       (lent),
      .ext_addr   (ext_addr),
      .ext_wdata  (ext_wdata),
      .ext_we     (ext_we),
      .space_sel  (space_sel),
      .ext_oe     (ext_oe)
   );

   assign pm_done    = last && (owner == OWN_PM);
   assign dm_done    = last && (owner == OWN_DM);
   assign rd_data    = ext_rdata;
   assign ext_grant  = lent;
   assign core_stall = lent && (halt_mode || pm_req || dm_req);

   // R2: never more than one space owns the bus
   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(space_sel));
   // R2: completion only happens inside an owned cycle
   p_done_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_done || dm_done) |-> (space_sel != '0));
   // R4: bus values hold for the whole access
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (space_sel != '0 && $past(space_sel) != '0) |-> ($stable(ext_addr) && $stable(ext_wdata) && $stable(ext_we)));
   // R6: a turnaround cycle follows every access
   p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_done || dm_done) |=> (space_sel == '0));
   // R7: the grant begins only after a cycle with no owner
   p_grant_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_grant) |-> ($past(space_sel) == '0));
   // R8: pins are released during the grant
   p_lent_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_grant |-> (!ext_oe && space_sel == '0));
   // R9: no stall without a grant
   p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_grant) |-> (!core_stall));
   // R10: halt mode stalls through the grant
   p_halt_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_grant && halt_mode) |-> core_stall);
   // R11: no port completes while the bus is lent
   p_no_done_lent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ext_grant |-> (!pm_done && !dm_done));
endmodule

// File: tb/sim_ext_bus_arbiter.sv
module sim_ext_bus_arbiter;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int WSW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           halt_mode = 1'b0;
   logic [WSW-1:0] ws_pm = '0, ws_dm = '0, ws_boot = '0;
   logic           pm_req = 1'b0, pm_boot = 1'b0, pm_we = 1'b0;
   logic [AW-1:0]  pm_addr = '0;
   logic [DW-1:0]  pm_wdata = '0;
   logic           dm_req = 1'b0, dm_we = 1'b0;
   logic [AW-1:0]  dm_addr = '0;
   logic [DW-1:0]  dm_wdata = '0;
   logic           ext_req = 1'b0;
   logic [DW-1:0]  ext_rdata = '0;
   logic           pm_done, dm_done, ext_grant, core_stall, ext_we, ext_oe;
   logic [DW-1:0]  rd_data, ext_wdata;
   logic [AW-1:0]  ext_addr;
   logic [2:0]     space_sel;

   int checks = 0;
   int errors = 0;
   int seed_dummy;

   always #10 clk = ~clk;

   ext_bus_arbiter #(.AW(AW), .DW(DW), .WSW(WSW)) u0 (
      .clk(clk), .rst_n(rst_n), .halt_mode(halt_mode),
      .ws_pm(ws_pm), .ws_dm(ws_dm), .ws_boot(ws_boot),
      .pm_req(pm_req), .pm_boot(pm_boot), .pm_addr(pm_addr), .pm_we(pm_we),
      .pm_wdata(pm_wdata), .pm_done(pm_done),
      .dm_req(dm_req), .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
      .dm_done(dm_done), .rd_data(rd_data),
      .ext_req(ext_req), .ext_grant(ext_grant), .core_stall(core_stall),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we),
      .ext_rdata(ext_rdata), .ext_oe(ext_oe), .space_sel(space_sel)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_sel(input bit dm, input bit boot);
      if (dm) return 3'b010;
      return boot ? 3'b100 : 3'b001;
   endfunction

   function automatic int exp_len(input bit dm, input bit boot);
      if (dm) return int'(ws_dm) + 1;
      return boot ? int'(ws_boot) + 1 : int'(ws_pm) + 1;
   endfunction

   // one complete access through a port, checked cycle by cycle
   task automatic run_access(input bit dm, input bit boot, input logic [AW-1:0] a,
                             input bit we, input logic [DW-1:0] wd);
      int  n = 0;
      bit  got = 0;
      int  len;
      @(negedge clk);
      len = exp_len(dm, boot);
      if (dm) begin
         dm_req = 1'b1; dm_addr = a; dm_we = we; dm_wdata = wd;
      end else begin
         pm_req = 1'b1; pm_boot = boot; pm_addr = a; pm_we = we; pm_wdata = wd;
      end
      while (!got && n < 20) begin
         @(negedge clk);
         n++;
         ext_rdata = DW'($urandom);
         #1;
         chk(space_sel == exp_sel(dm, boot), "R5 space_sel", int'(space_sel), int'(exp_sel(dm, boot)));
         chk(ext_addr == a && ext_wdata == wd && ext_we == we, "R4 bus values", int'(ext_addr), int'(a));
         if (dm ? dm_done : pm_done) begin
            got = 1;
            chk(n == len, "R2 R3 access length", n, len);
            chk(rd_data == ext_rdata, "R4 read data", int'(rd_data), int'(ext_rdata));
            dm_req = 1'b0; pm_req = 1'b0; pm_boot = 1'b0;
         end else begin
            chk((dm ? pm_done : dm_done) == 1'b0, "R2 wrong done", 1, 0);
         end
      end
      chk(got, "R2 access completed", int'(got), 1);
      @(negedge clk);
      chk(space_sel == 3'b000, "R6 idle gap", int'(space_sel), 0);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int n;
      bit seen;
      seed_dummy = $urandom(32'd5150);

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(ext_grant == 0 && space_sel == 0 && pm_done == 0 && dm_done == 0, "R1 in reset", int'(space_sel), 0);
      chk(ext_oe == 1 && core_stall == 0, "R1 oe in reset", int'(ext_oe), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ext_grant == 0 && space_sel == 0 && ext_oe == 1, "R1 after reset", int'(space_sel), 0);

      // R2 R3 boundary: zero and maximum waits, boot versus program
      ws_pm = 3'd0; ws_dm = 3'd4; ws_boot = 3'd7;
      run_access(1'b0, 1'b0, 16'h0101, 1'b0, 16'h0000);
      run_access(1'b0, 1'b1, 16'h0202, 1'b0, 16'h0000);
      run_access(1'b1, 1'b0, 16'h0303, 1'b1, 16'hBEEF);

      // R2 R3 R4 random single accesses
      for (int i = 0; i < 40; i++) begin
         bit dm, boot;
         @(negedge clk);
         ws_pm = WSW'($urandom); ws_dm = WSW'($urandom); ws_boot = WSW'($urandom);
         dm = 1'($urandom); boot = dm ? 1'b0 : 1'($urandom);
         run_access(dm, boot, AW'($urandom), 1'($urandom), DW'($urandom));
      end

      // R5 R6 both ports in the same cycle
      @(negedge clk);
      ws_dm = 3'd2; ws_pm = 3'd1;
      dm_req = 1'b1; dm_addr = 16'hD000; pm_req = 1'b1; pm_addr = 16'hA000;
      @(negedge clk);
      chk(space_sel == 3'b010, "R5 data first", int'(space_sel), 2);
      n = 1;
      while (!dm_done && n < 20) begin @(negedge clk); n++; end
      chk(n == 3 && pm_done == 0, "R5 data length", n, 3);
      dm_req = 1'b0;
      @(negedge clk);
      chk(space_sel == 3'b000, "R6 gap between ports", int'(space_sel), 0);
      @(negedge clk);
      chk(space_sel == 3'b001 && ext_addr == 16'hA000, "R5 program second", int'(space_sel), 1);
      @(negedge clk);
      chk(pm_done == 1, "R5 program done", int'(pm_done), 1);
      pm_req = 1'b0;
      repeat (2) @(negedge clk);

      // R12 outside master wins at idle
      halt_mode = 1'b0;
      ext_req = 1'b1; pm_req = 1'b1; pm_addr = 16'h1234; ws_pm = 3'd0;
      @(negedge clk); #1;
      chk(ext_grant == 1 && space_sel == 0, "R12 grant first", int'(ext_grant), 1);
      chk(ext_oe == 0, "R8 released", int'(ext_oe), 0);
      chk(core_stall == 1, "R9 stall with port request", int'(core_stall), 1);
      ext_req = 1'b0;
      @(negedge clk); #1;
      chk(ext_grant == 0 && ext_oe == 1, "R8 grant drops", int'(ext_grant), 0);
      @(negedge clk); #1;
      chk(space_sel == 3'b001 && pm_done == 1, "R11 served after grant", int'(space_sel), 1);
      pm_req = 1'b0;
      repeat (2) @(negedge clk);

      // R7 request in the middle of a long access
      ws_pm = 3'd5; pm_req = 1'b1; pm_addr = 16'h5555;
      @(negedge clk);
      ext_req = 1'b1;
      n = 0;
      while (space_sel != 0 && n < 20) begin
         chk(ext_grant == 0, "R7 no grant mid access", int'(ext_grant), 0);
         if (pm_done) pm_req = 1'b0;
         @(negedge clk);
         n++;
      end
      seen = 0;
      for (int k = 0; k < 3 && !seen; k++) begin
         if (ext_grant) seen = 1; else @(negedge clk);
      end
      chk(seen, "R7 grant after access", int'(seen), 1);
      #1;
      chk(core_stall == 0, "R9 continue no stall", int'(core_stall), 0);
      chk(ext_oe == 0 && space_sel == 0, "R8 lines released", int'(ext_oe), 0);
      dm_req = 1'b1; dm_addr = 16'h7777; ws_dm = 3'd0;
      #1;
      chk(core_stall == 1, "R9 continue stall on request", int'(core_stall), 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); #1;
         chk(dm_done == 0 && ext_grant == 1, "R11 held during grant", int'(dm_done), 0);
      end
      ext_req = 1'b0;
      seen = 0;
      for (int k = 0; k < 5 && !seen; k++) begin
         @(negedge clk); #1;
         if (dm_done) seen = 1;
      end
      chk(seen, "R11 served after release", int'(seen), 1);
      dm_req = 1'b0;
      repeat (2) @(negedge clk);

      // R10 halt mode
      halt_mode = 1'b1; ext_req = 1'b1;
      @(negedge clk); #1;
      chk(ext_grant == 1 && core_stall == 1, "R10 halt stall", int'(core_stall), 1);
      repeat (3) @(negedge clk);
      #1;
      chk(core_stall == 1, "R10 halt stall held", int'(core_stall), 1);
      ext_req = 1'b0;
      @(negedge clk); #1;
      chk(ext_grant == 0 && core_stall == 0, "R10 stall ends", int'(core_stall), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule